// File: doc/BRIEF.md
# Atomic Wide Register Target for a Byte-Wide Register Bus

This block is one target on a register bus that carries 8-bit data, moves one transfer per cycle and has no acknowledge. The target holds one register that is wider than the bus. Its bytes sit at consecutive addresses starting at a base address, with the least significant byte first. Read data is always due in the cycle after the access, with a fixed latency like a synchronous RAM. When the target is not read, its read data is zero, so the read data of many targets can be merged with a plain OR.

A wide value that is read or written one byte at a time can tear: the core logic may change the value between two byte accesses. Reads avoid this with a snapshot. A read of the lowest byte with the read strobe high returns that byte live and, at the same edge, copies all the upper bytes into a shadow buffer. Reads of the upper bytes return the shadow copy. Writes avoid it by gathering the lower bytes in a write buffer. The register takes all its bytes in one cycle, when the highest byte is written. The core logic sees the register value on its own output and may load a new value through its own write port.

Top module: `atomicWideRegTarget`

## Requirements
- R1: While reset is held and after it is released, the register output equals the parameter RESET_VAL and the bus read data is zero.
- R2: Read data for a read-enabled access appears exactly one cycle after that access and lasts one cycle only. If no read follows, the read data is zero in the next cycle.
- R3: A read-enabled access at the base address (byte 0) returns bits 7:0 of the register value as it stood in the cycle of the access. At the same edge it captures bits DATA_W-1:8 into the shadow buffer.
- R4: A read-enabled access at base+k, with k from 1 to REG_BYTES-1, returns shadow byte k, which holds bits 8k+7:8k from the last byte-0 read. Core loads that happen after that byte-0 read do not change the returned data.
- R5: A bus write to base+k, with k below REG_BYTES-1, stores the byte in write buffer slot k and leaves the register output unchanged.
- R6: A bus write to base+REG_BYTES-1 sets the whole register in one cycle. The written byte becomes the top byte and buffer slot k becomes bits 8k+7:8k (little-endian).
- R7: When a bus commit and a core load happen in the same cycle, the bus commit wins. Without a bus commit, a core load sets the register to the core data in the next cycle.
- R8: An access outside base to base+REG_BYTES-1 changes no state and returns zero read data.
- R9: An in-range access with the read strobe low returns zero read data, even when the write strobe is high. It does not disturb the shadow buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the bus access |
| busWe | input | 1 | Bus write strobe |
| busRe | input | 1 | Bus read strobe |
| busWdata | input | 8 | Bus write byte |
| busRdata | output | 8 | Bus read byte, due one cycle after the access, zero when not read |
| coreWe | input | 1 | Core-side load strobe |
| coreWdata | input | REG_BYTES*8 | Core-side load value |
| regValue | output | REG_BYTES*8 | Current register value seen by the core |

## Verification
Every result of this target is due one clock edge after the access that causes it. The read byte is due at the edge after the read-enabled access. The register output changes at the edge after a commit or a core load. The shadow buffer takes its copy at the edge of the byte-0 read. The bench drives each access on the falling edge and moves its reference model forward once per rising edge. It compares both outputs one time step after that rising edge, so each check looks at exactly the cycle in which the requirement says the value is due.

// File: rtl/atomicWideRegPkg.sv
package atomicWideRegPkg;
  // Strobes from address decode to datapath, one per kind of bus action.
  typedef struct packed {
    logic snapRd;    // read of byte 0: return live byte, capture upper bytes
    logic shadowRd;  // read of an upper byte from the snapshot
    logic bufWr;     // write of a lower byte into the write buffer
    logic commit;    // write of the top byte, commit whole value
  } regStrobes_t;
endpackage

// File: rtl/atomicWideRegCtrl.sv
module atomicWideRegCtrl
  import atomicWideRegPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h40,
  parameter int REG_BYTES = 4,
  localparam int IDX_W    = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output regStrobes_t       stb,
  output logic [IDX_W-1:0]  byteIdx
);
  localparam logic [ADDR_W:0] LO_ADDR  = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] HI_ADDR  = (ADDR_W+1)'(BASE_ADDR + REG_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_BYTES - 1);

  logic [ADDR_W:0] addrExt;
  logic            hit;

  always_comb begin
    addrExt = {1'b0, busAddr};
    hit     = (addrExt >= LO_ADDR) && (addrExt < HI_ADDR);
    byteIdx = IDX_W'(addrExt - LO_ADDR);
  end

  always_comb begin
    stb          = '0;
    stb.snapRd   = hit && busRe && (byteIdx == '0);
    stb.shadowRd = hit && busRe && (byteIdx != '0);
    stb.bufWr    = hit && busWe && (byteIdx != LAST_IDX);
    stb.commit   = hit && busWe && (byteIdx == LAST_IDX);
  end

  // R3: a read is either a live/snapshot read or a shadow read, never both
  p_read_kind_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.snapRd, stb.shadowRd}));

  // R6: a write either fills the buffer or commits, never both
  p_write_kind_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.bufWr, stb.commit}));

  // R9: no read strobe without the bus read enable
  p_no_read_without_re_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |-> !(stb.snapRd || stb.shadowRd));
endmodule

// File: rtl/atomicWideRegDatapath.sv
module atomicWideRegDatapath
  import atomicWideRegPkg::*;
#(
  parameter int REG_BYTES          = 4,
  parameter logic [REG_BYTES*8-1:0] RESET_VAL = '0,
  localparam int DATA_W            = REG_BYTES * 8,
  localparam int IDX_W             = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       stb,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [7:0]        busWdata,
  input  logic              coreWe,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [7:0]        busRdata,
  output logic [DATA_W-1:0] regValue
);
  logic [DATA_W-1:0]   liveReg;
  logic [DATA_W-9:0]   shadowBuf;   // bytes 1..REG_BYTES-1
  logic [DATA_W-9:0]   writeBuf;    // bytes 0..REG_BYTES-2
  logic [7:0]          shadowByte;
  logic [7:0]          rdNext;

  // Write buffer lanes, one per lower byte.
  for (genvar lane = 0; lane < REG_BYTES - 1; lane++) begin : g_wbuf
    always_ff @(posedge clk) begin
      if (!rstN) begin
        writeBuf[lane*8 +: 8] <= '0;
      end else if (stb.bufWr && (byteIdx == IDX_W'(lane))) begin
        writeBuf[lane*8 +: 8] <= busWdata;
      end
    end
  end

  // Shadow buffer: whole upper part captured on a byte-0 read.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowBuf <= '0;
    end else if (stb.snapRd) begin
      shadowBuf <= liveReg[DATA_W-1:8];
    end
  end

  // Live register: bus commit has priority over a core load.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveReg <= RESET_VAL;
    end else if (stb.commit) begin
      liveReg <= {busWdata, writeBuf};
    end else if (coreWe) begin
      liveReg <= coreWdata;
    end
  end

  // Select the shadow byte addressed by byteIdx.
  always_comb begin
    shadowByte = '0;
    for (int lane = 1; lane < REG_BYTES; lane++) begin
      if (byteIdx == IDX_W'(lane)) shadowByte = shadowBuf[(lane-1)*8 +: 8];
    end
  end

  always_comb begin
    if (stb.snapRd)        rdNext = liveReg[7:0];
    else if (stb.shadowRd) rdNext = shadowByte;
    else                   rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else       busRdata <= rdNext;
  end

  assign regValue = liveReg;

  // R3: byte-0 read returns the live low byte one cycle later
  p_live_low_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.snapRd |=> busRdata == $past(regValue[7:0]));

  // R3: the snapshot holds the upper bytes seen at the byte-0 read
  p_snapshot_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.snapRd |=> shadowBuf == $past(regValue[DATA_W-1:8]));

  // R4: the snapshot only moves on a byte-0 read
  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.snapRd |=> $stable(shadowBuf));

  // R9 / R2: no read strobe means zero read data next cycle
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.snapRd || stb.shadowRd) |=> busRdata == 8'h00);

  // R5: a buffered byte write leaves the register untouched
  p_buffer_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.bufWr && !coreWe) |=> $stable(regValue));

  // R7: a bus commit beats a core load in the same cycle
  p_commit_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit && coreWe) |=> regValue[DATA_W-1 -: 8] == $past(busWdata));
endmodule

// File: rtl/atomicWideRegTarget.sv
module atomicWideRegTarget
  import atomicWideRegPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h40,
  parameter int REG_BYTES = 4,
  parameter logic [REG_BYTES*8-1:0] RESET_VAL = 32'h1234_5678,
  localparam int DATA_W   = REG_BYTES * 8,
  localparam int IDX_W    = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic              coreWe,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [DATA_W-1:0] regValue
);
  regStrobes_t      stb;
  logic [IDX_W-1:0] byteIdx;

  atomicWideRegCtrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .REG_BYTES(REG_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .stb(stb), .byteIdx(byteIdx)
  );

  atomicWideRegDatapath #(
    .REG_BYTES(REG_BYTES), .RESET_VAL(RESET_VAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .byteIdx(byteIdx),
    .busWdata(busWdata), .coreWe(coreWe), .coreWdata(coreWdata),
    .busRdata(busRdata), .regValue(regValue)
  );

  // R1: read data is zero during reset release
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> busRdata == 8'h00);
endmodule

// File: tb/sim_atomicWideRegTarget.sv
module sim_atomicWideRegTarget;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int BASE       = 'h40;
  localparam int NB         = 4;
  localparam int DW         = NB * 8;
  localparam logic [DW-1:0] RST_VAL = 32'h1234_5678;

  logic clk = 0;
  logic rstN = 0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWe = 0, busRe = 0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic coreWe = 0;
  logic [DW-1:0] coreWdata = '0;
  logic [DW-1:0] regValue;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mReg = RST_VAL;
  logic [DW-1:0] mShadow = '0;
  logic [DW-1:0] mWbuf = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomicWideRegTarget #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .REG_BYTES(NB),
    .RESET_VAL(RST_VAL)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .coreWe(coreWe),
    .coreWdata(coreWdata), .regValue(regValue));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic inRange(input int a);
    return (a >= BASE) && (a < BASE + NB);
  endfunction

  // One bus cycle: drive at falling edge, advance model at rising edge, check after it.
  task automatic step(input int a, input logic we, input logic re, input logic [7:0] wd,
                      input logic cwe, input logic [DW-1:0] cd);
    logic [7:0] expRd;
    string rdTag, rgTag;
    int k;
    busAddr = ADDR_W'(a); busWe = we; busRe = re; busWdata = wd;
    coreWe = cwe; coreWdata = cd;
    k = a - BASE;
    expRd = '0;
    if (!inRange(a)) rdTag = "R8";
    else if (!re) rdTag = "R9";
    else if (k == 0) begin rdTag = "R3"; expRd = mReg[7:0]; end
    else begin rdTag = "R4"; expRd = mShadow[k*8 +: 8]; end
    if (re && inRange(a) && k == 0) mShadow = mReg;
    rgTag = "R8";
    if (we && inRange(a) && k == NB-1) begin
      mReg = {wd, mWbuf[DW-9:0]};
      rgTag = cwe ? "R7" : "R6";
    end else begin
      if (we && inRange(a)) begin mWbuf[k*8 +: 8] = wd; rgTag = "R5"; end
      if (cwe) begin mReg = cd; rgTag = "R7"; end
    end
    @(posedge clk); #1;
    check(rdTag, DW'(busRdata), DW'(expRd));
    check(rgTag, regValue, mReg);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R1", regValue, RST_VAL);
    check("R1", DW'(busRdata), '0);
    @(negedge clk); rstN = 1;
    @(posedge clk); #1;
    check("R1", regValue, RST_VAL);
    check("R1", DW'(busRdata), '0);
    @(negedge clk);

    // R3/R4: snapshot survives a core load between byte reads
    step(BASE, 0, 0, 0, 1, 32'hA1B2_C3D4);
    step(BASE, 0, 1, 0, 0, 0);
    step(BASE, 0, 0, 0, 1, 32'h0F0E_0D0C);
    step(BASE+1, 0, 1, 0, 0, 0);
    step(BASE+2, 0, 1, 0, 0, 0);
    step(BASE+3, 0, 1, 0, 0, 0);
    // R2: read data lasts one cycle only
    step(BASE, 0, 0, 0, 0, 0);
    // R5/R6: lower bytes buffered, top byte commits
    step(BASE, 1, 0, 8'h11, 0, 0);
    step(BASE+1, 1, 0, 8'h22, 0, 0);
    step(BASE+2, 1, 0, 8'h33, 0, 0);
    step(BASE+3, 1, 0, 8'h44, 0, 0);
    check("R6", regValue, 32'h4433_2211);
    // R7: commit and core load together
    step(BASE+3, 1, 0, 8'h99, 1, 32'hDEAD_BEEF);
    check("R7", regValue, 32'h9933_2211);
    // R8: out-of-range write and read
    step(BASE+NB, 1, 1, 8'hFF, 0, 0);
    step(BASE-1, 1, 1, 8'hFF, 0, 0);
    // R9: write without read enable returns zero
    step(BASE, 1, 0, 8'h55, 0, 0);

    for (int i = 0; i < 4000; i++) begin
      int a;
      a = BASE - 1 + int'($urandom % (NB + 2));
      if (($urandom % 16) == 0) a = int'($urandom % 256);
      step(a, ($urandom % 3) == 0, ($urandom % 2) == 0, 8'($urandom),
           ($urandom % 5) == 0, DW'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule